// File: doc/BRIEF.md
# Dual-Bank Two-Wire Serial Memory Target

This block is the target side of a two-wire serial memory bus. It holds two byte-wide storage banks of 2048 locations each. It watches the clock line (SCL) and data line (SDA), which are sampled on a faster system clock, and answers as a serial memory would. A controller opens a transfer with a start condition and then sends a control byte. The upper nibble of that byte picks a bank, bit 0 gives the direction, and bits 3:1 carry the upper address bits. In a write, a word-address byte follows, and then any number of data bytes. In a read, bytes are shifted out from the current address pointer.

The block never drives SDA high. Its only output is a pull-low enable for an external open-drain pad. The enable is raised for acknowledge bits and for zero data bits, and nowhere else. To read from a chosen address, the controller sends a dummy write that carries only the address, then a repeated start, then a read control byte. Right after reset the block sweeps all of its storage to 0xFF. It ignores the bus until that sweep is done.

Top module: `serstore_top`

## Requirements
- R1: For BANK_BYTES clock cycles after reset the block fills every location of both banks with 0xFF. During that time it ignores all bus activity and keeps sda_oe low. After the fill, a read from any location returns 0xFF.
- R2: A control byte is acknowledged only when its bits 7:4 equal a bank base: 4'hA selects bank 0 and 4'hE selects bank 1. Bit 0 of the control byte selects a read (1) or a write (0).
- R3: In a write, control bits 3:1 set address bits 10:8 and the word-address byte sets address bits 7:0. A different value in bits 3:1 reaches a different location.
- R4: SDA falling while SCL is high (start) aborts any transfer and expects a control byte next. SDA rising while SCL is high (stop) returns the block to idle. Both release SDA. After a stop, clocked bytes get no acknowledge until a new start.
- R5: Bits are taken MSB first on SCL rising edges. After a received byte that is acknowledged, sda_oe is high for the ninth clock and drops after the SCL falling edge that follows. sda_oe changes only while SCL is low, except for the release at a start or stop.
- R6: A control byte whose upper nibble matches no bank is not acknowledged. Every later byte before the next start is also not acknowledged, and no byte from it is stored.
- R7: Each data byte after the word address is stored at the current address and acknowledged. The address then increments modulo 2048, so 0x7FF is followed by 0x000 in the same bank.
- R8: In a read, the byte at the current address is sent MSB first and the address increments after the byte. A controller acknowledge (SDA low on the ninth clock) gets the next byte, including across the wrap from 0x7FF to 0x000. A read control byte with no word address continues from the pointer left by the last transfer.
- R9: When the controller does not acknowledge a read byte, the block drives nothing more until the next start. Further clocked bytes read as all ones.
- R10: A write holding only the control and word-address bytes, followed by a repeated start and a read control byte, returns the byte at that address.
- R11: sda_oe is raised only for an acknowledge or a zero data bit. Reading a byte of 0xFF leaves SDA undriven for all eight data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock as seen at the pad |
| sda_i | input | 1 | Serial data as seen at the pad (wired-AND bus level) |
| sda_oe | output | 1 | Active-high pull-low enable for the SDA pad |

## Verification
The bench runs sequential writes of six bytes into both banks. Each run starts at three points: the bottom of a bank, a mid-range address with nonzero upper bits, and a point just below the top, so the run wraps. The data is computed from bank and address, so reading it back through random reads tells apart a bank mix-up, a lost upper address bit and a wrong wrap. Reads of untouched locations, a current-address continuation, an unknown control nibble, a start in the middle of a byte, a stop followed by bare clocking and a controller non-acknowledge each test one exit path of the transfer state. Reading erased bytes shows that nothing is driven for ones.

// File: rtl/serstore_pkg.sv
package serstore_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_WADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_e;

  // Strobes from the bus sequencer to the storage datapath.
  typedef struct packed {
    logic shiftIn;    // take one SDA bit into the receive shifter
    logic latchCtrl;  // matched control byte: keep bank and upper address bits
    logic setAddr;    // word-address byte complete: load the pointer
    logic storeByte;  // data byte complete: write it and advance the pointer
    logic bumpAddr;   // read byte fully sent: advance the pointer
    logic loadOut;    // fetch the byte at the pointer into the send shifter
    logic shiftOut;   // advance the send shifter by one bit
  } strobe_t;

endpackage

// File: rtl/serstore_dpath.sv
module serstore_dpath
  import serstore_pkg::*;
#(
  parameter int BANK_BYTES = 2048,
  parameter int NUM_BANKS  = 2,
  parameter logic [NUM_BANKS*4-1:0] BANK_BASES = 8'hEA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sdaBit,
  input  strobe_t    strobe,
  output logic [7:0] byteNow,
  output logic       ctrlHit,
  output logic       memMsb,
  output logic       txNext,
  output logic       initBusy
);

  localparam int ADDR_W = $clog2(BANK_BYTES);
  localparam int SEL_W  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int HI_W   = 3;

  logic [6:0]        rxShift;
  logic [6:0]        txShift;
  logic [HI_W-1:0]   ctrlHigh;
  logic [SEL_W-1:0]  bankSel;
  logic [SEL_W-1:0]  hitIdx;
  logic [ADDR_W-1:0] addrPtr;
  logic [ADDR_W:0]   clrCnt;
  logic [7:0]        bankOut [NUM_BANKS];
  logic [7:0]        memWord;

  assign byteNow  = {rxShift, sdaBit};
  assign initBusy = ~clrCnt[ADDR_W];
  assign memWord  = bankOut[bankSel];
  assign memMsb   = memWord[7];
  assign txNext   = txShift[6];

  always_comb begin
    ctrlHit = 1'b0;
    hitIdx  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (byteNow[7:4] == BANK_BASES[b*4 +: 4]) begin
        ctrlHit = 1'b1;
        hitIdx  = SEL_W'(b);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift  <= '0;
      txShift  <= '1;
      ctrlHigh <= '0;
      bankSel  <= '0;
      addrPtr  <= '0;
      clrCnt   <= '0;
    end else begin
      if (initBusy) clrCnt <= clrCnt + 1'b1;
      if (strobe.shiftIn) rxShift <= byteNow[6:0];
      if (strobe.latchCtrl) begin
        bankSel  <= hitIdx;
        ctrlHigh <= byteNow[3:1];
      end
      if (strobe.setAddr) addrPtr <= ADDR_W'({ctrlHigh, byteNow});
      if (strobe.storeByte || strobe.bumpAddr) addrPtr <= addrPtr + 1'b1;
      if (strobe.loadOut) txShift <= memWord[6:0];
      else if (strobe.shiftOut) txShift <= {txShift[5:0], 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [7:0] cells [BANK_BYTES];
    always_ff @(posedge clk) begin
      if (initBusy) cells[clrCnt[ADDR_W-1:0]] <= 8'hFF;
      else if (strobe.storeByte && bankSel == SEL_W'(g)) cells[addrPtr] <= byteNow;
    end
    assign bankOut[g] = cells[addrPtr];
  end

endmodule

// File: rtl/serstore_ctrl.sv
module serstore_ctrl
  import serstore_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       initBusy,
  input  logic [7:0] byteNow,
  input  logic       ctrlHit,
  input  logic       memMsb,
  input  logic       txNext,
  output strobe_t    strobe,
  output logic       sdaBit,
  output logic       sdaOe
);

  logic [1:0] sclQ, sdaQ;
  logic       sclPrev, sdaPrev;
  logic       sclS, sdaS;
  logic       sclRise, sclFall, startEv, stopEv;
  phase_e     phase;
  logic [3:0] bitCnt;
  logic       ackFlag;

  assign sclS    = sclQ[1];
  assign sdaS    = sdaQ[1];
  assign sdaBit  = sdaS;
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclQ    <= 2'b11;
      sdaQ    <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclQ    <= {sclQ[0], scl_i};
      sdaQ    <= {sdaQ[0], sda_i};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  logic busActive;
  assign busActive = ~initBusy & ~startEv & ~stopEv & (phase != PH_IDLE);

  always_comb begin
    strobe = '0;
    if (busActive) begin
      if (sclRise && bitCnt < 4'd8) begin
        strobe.shiftIn = 1'b1;
        if (bitCnt == 4'd7) begin
          case (phase)
            PH_CTRL:  strobe.latchCtrl = ctrlHit;
            PH_WADDR: strobe.setAddr   = 1'b1;
            PH_WDATA: strobe.storeByte = 1'b1;
            PH_RDATA: strobe.bumpAddr  = 1'b1;
            default:  ;
          endcase
        end
      end
      if (sclFall && phase == PH_RDATA) begin
        strobe.loadOut  = (bitCnt == 4'd9);
        strobe.shiftOut = (bitCnt >= 4'd1) && (bitCnt <= 4'd7);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bitCnt  <= '0;
      ackFlag <= 1'b0;
      sdaOe   <= 1'b0;
    end else if (!initBusy) begin
      if (startEv) begin
        phase   <= PH_CTRL;
        bitCnt  <= '0;
        ackFlag <= 1'b0;
        sdaOe   <= 1'b0;
      end else if (stopEv) begin
        phase   <= PH_IDLE;
        bitCnt  <= '0;
        ackFlag <= 1'b0;
        sdaOe   <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (sclRise) begin
          if (bitCnt == 4'd8) begin
            bitCnt <= 4'd9;
            if (phase == PH_RDATA && !ackFlag && sdaS) phase <= PH_SKIP;
          end else if (bitCnt < 4'd8) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == 4'd7) begin
              case (phase)
                PH_CTRL: begin
                  ackFlag <= ctrlHit;
                  phase   <= !ctrlHit ? PH_SKIP : (byteNow[0] ? PH_RDATA : PH_WADDR);
                end
                PH_WADDR: begin
                  ackFlag <= 1'b1;
                  phase   <= PH_WDATA;
                end
                PH_WDATA: ackFlag <= 1'b1;
                default:  ackFlag <= 1'b0;
              endcase
            end
          end
        end else if (sclFall) begin
          if (bitCnt == 4'd8) begin
            sdaOe <= ackFlag;
          end else if (bitCnt == 4'd9) begin
            bitCnt <= '0;
            sdaOe  <= (phase == PH_RDATA) ? ~memMsb : 1'b0;
          end else if (bitCnt >= 4'd1 && phase == PH_RDATA) begin
            sdaOe <= ~txNext;
          end
        end
      end
    end
  end

endmodule

// File: rtl/serstore_top.sv
module serstore_top #(
  parameter int BANK_BYTES = 2048,
  parameter int NUM_BANKS  = 2,
  parameter logic [NUM_BANKS*4-1:0] BANK_BASES = 8'hEA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  serstore_pkg::strobe_t strobe;
  logic [7:0] byteNow;
  logic ctrlHit, memMsb, txNext, initBusy, sdaBit;

  serstore_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .initBusy(initBusy), .byteNow(byteNow), .ctrlHit(ctrlHit),
    .memMsb(memMsb), .txNext(txNext), .strobe(strobe),
    .sdaBit(sdaBit), .sdaOe(sda_oe)
  );

  serstore_dpath #(
    .BANK_BYTES(BANK_BYTES), .NUM_BANKS(NUM_BANKS), .BANK_BASES(BANK_BASES)
  ) uDpath (
    .clk(clk), .rst_n(rst_n), .sdaBit(sdaBit), .strobe(strobe),
    .byteNow(byteNow), .ctrlHit(ctrlHit), .memMsb(memMsb),
    .txNext(txNext), .initBusy(initBusy)
  );

endmodule

// File: rtl/serstore_chk.sv
module serstore_chk #(
  parameter int BANK_BYTES = 2048
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe
);

  localparam int CW = $clog2(BANK_BYTES) + 1;

  logic [CW-1:0] initCnt;
  logic [1:0] sclQ, sdaQ;
  logic sclPrev, sdaPrev, sclS, sdaS, startSeen, stopSeen;

  assign sclS      = sclQ[1];
  assign sdaS      = sdaQ[1];
  assign startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      initCnt <= '0;
      sclQ    <= 2'b11;
      sdaQ    <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      if (initCnt < CW'(BANK_BYTES)) initCnt <= initCnt + 1'b1;
      sclQ    <= {sclQ[0], scl_i};
      sdaQ    <= {sdaQ[0], sda_i};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  a_r1_quiet_init: assert property (@(posedge clk) disable iff (!rst_n)
    (initCnt < CW'(BANK_BYTES)) |-> !sda_oe);

  a_r4_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    startSeen |=> !sda_oe);

  a_r4_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stopSeen |=> !sda_oe);

  a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !sclS);

  a_r5_release_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!sclS || $past(startSeen) || $past(stopSeen)));

endmodule

bind serstore_top serstore_chk #(.BANK_BYTES(BANK_BYTES)) uChk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe)
);

// File: tb/serstore_top_test.sv
`timescale 1ns/1ps
module serstore_top_test;

  localparam int BYTES = 2048;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic sdaLine;
  int   nChk = 0;
  int   nBad = 0;
  bit   finished = 1'b0;

  assign sdaLine = sdaM & ~sdaOe;

  always #2 clk = ~clk;

  serstore_top uut (
    .clk(clk), .rst_n(rst_n), .scl_i(sclM), .sda_i(sdaLine), .sda_oe(sdaOe)
  );

  function automatic logic [7:0] pat(int bank, int a);
    return 8'((a * 7) + (bank * 85) + 3);
  endfunction

  function automatic logic [3:0] baseOf(int bank);
    return (bank != 0) ? 4'hE : 4'hA;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
  endtask

  task automatic clockBit(logic v);
    sdaM = v;    tick(Q);
    sclM = 1'b1; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic sendByte(logic [7:0] b, bit relCheck, output bit ack);
    for (int i = 7; i >= 0; i--) clockBit(b[i]);
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q / 2);
    ack = ~sdaLine;
    tick(Q / 2);
    sclM = 1'b0; tick(Q);
    if (relCheck) chk(!sdaOe, "R5 release after ninth clock", sdaOe, 0);
  endtask

  task automatic recvByte(bit mAck, output logic [7:0] b, output bit anyOe);
    anyOe = 1'b0;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclM = 1'b1; tick(Q / 2);
      b[i] = sdaLine;
      if (sdaOe) anyOe = 1'b1;
      tick(Q / 2);
      sclM = 1'b0;
    end
    tick(Q);
    sdaM = ~mAck; tick(Q);
    sclM = 1'b1; tick(Q);
    sclM = 1'b0; tick(Q);
    sdaM = 1'b1;
  endtask

  task automatic setPtr(int bank, int addr, string req);
    bit ack;
    busStart();
    sendByte({baseOf(bank), 3'(addr >> 8), 1'b0}, 1'b1, ack);
    chk(ack, {req, " control ack"}, ack, 1);
    sendByte(8'(addr), 1'b1, ack);
    chk(ack, {req, " word address ack"}, ack, 1);
  endtask

  task automatic readCtrl(int bank, string req);
    bit ack;
    busStart();
    sendByte({baseOf(bank), 3'b000, 1'b1}, 1'b0, ack);
    chk(ack, {req, " read control ack"}, ack, 1);
  endtask

  task automatic readRun(int bank, int addr, int n, string req);
    logic [7:0] b;
    bit anyOe;
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, b, anyOe);
      chk(b == pat(bank, (addr + i) % BYTES), req, b, pat(bank, (addr + i) % BYTES));
    end
  endtask

  initial begin
    tick(200000);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    bit ack;
    bit anyOe;
    logic [7:0] b;
    int starts [3];
    starts = '{0, 'h3FC, 'h7FD};

    tick(10);
    rst_n = 1'b1;
    tick(50);
    // R1: quiet while filling, even if a valid control byte arrives
    chk(!sdaOe, "R1 sda_oe low after reset", sdaOe, 0);
    busStart();
    sendByte(8'hA0, 1'b1, ack);
    chk(!ack, "R1 bus ignored during fill", ack, 0);
    busStop();
    tick(BYTES + 100);

    // R1 R10 R11: erased contents read as 0xFF and nothing is driven
    setPtr(1, 'h123, "R10");
    readCtrl(1, "R10");
    for (int i = 0; i < 3; i++) begin
      recvByte(i != 2, b, anyOe);
      chk(b == 8'hFF, "R1 erased byte reads FF", b, 8'hFF);
      chk(!anyOe, "R11 no drive for one bits", anyOe, 0);
    end
    busStop();

    // R2 R3 R7: sequential writes in both banks, including the wrap
    for (int bank = 0; bank < 2; bank++) begin
      foreach (starts[s]) begin
        setPtr(bank, starts[s], "R2 R3");
        for (int i = 0; i < 6; i++) begin
          sendByte(pat(bank, (starts[s] + i) % BYTES), 1'b1, ack);
          chk(ack, "R7 data byte ack", ack, 1);
        end
        busStop();
      end
    end

    // R8 R10: random reads back, sequential with wrap
    for (int bank = 0; bank < 2; bank++) begin
      foreach (starts[s]) begin
        setPtr(bank, starts[s], "R10");
        readCtrl(bank, "R8");
        readRun(bank, starts[s], 6, "R8 sequential readback");
        busStop();
      end
    end

    // R3: upper bits zero reach a different, untouched location
    setPtr(0, 'h0FC, "R3");
    readCtrl(0, "R3");
    recvByte(1'b0, b, anyOe);
    chk(b == 8'hFF, "R3 upper bits select location", b, 8'hFF);
    busStop();

    // R8: current-address read continues from the pointer
    setPtr(0, 'h3FC, "R8");
    readCtrl(0, "R8");
    readRun(0, 'h3FC, 2, "R8 first part");
    busStop();
    readCtrl(0, "R8");
    readRun(0, 'h3FE, 3, "R8 current address continuation");
    busStop();

    // R6: unknown nibble, write then read form
    busStart();
    sendByte(8'hB0, 1'b1, ack);
    chk(!ack, "R6 unknown control not acked", ack, 0);
    sendByte(8'h00, 1'b1, ack);
    chk(!ack, "R6 later byte not acked", ack, 0);
    sendByte(8'h99, 1'b1, ack);
    chk(!ack, "R6 data byte not acked", ack, 0);
    busStop();
    busStart();
    sendByte(8'hC1, 1'b1, ack);
    chk(!ack, "R6 unknown read control not acked", ack, 0);
    recvByte(1'b0, b, anyOe);
    chk(b == 8'hFF && !anyOe, "R6 no data after unknown control", b, 8'hFF);
    busStop();
    setPtr(0, 0, "R6");
    readCtrl(0, "R6");
    readRun(0, 0, 2, "R6 contents unchanged");
    busStop();

    // R4: start in the middle of a data byte aborts it
    setPtr(0, 'h050, "R4");
    for (int i = 0; i < 4; i++) clockBit(1'b0);
    readCtrl(0, "R4");
    recvByte(1'b0, b, anyOe);
    chk(b == 8'hFF, "R4 aborted byte not stored", b, 8'hFF);
    busStop();
    // R4: after stop, bare clocking is not answered
    sendByte(8'hA0, 1'b1, ack);
    chk(!ack, "R4 idle after stop", ack, 0);
    busStop();

    // R9: controller not acknowledging ends the output
    setPtr(1, 0, "R9");
    readCtrl(1, "R9");
    recvByte(1'b0, b, anyOe);
    chk(b == pat(1, 0), "R9 byte before nack", b, pat(1, 0));
    recvByte(1'b0, b, anyOe);
    chk(b == 8'hFF && !anyOe, "R9 silent after nack", b, 8'hFF);
    busStop();
    chk(!sdaOe, "R4 released after stop", sdaOe, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

endmodule